// File: doc/BRIEF.md
# DMA Interrupt Vector Generator

This block gathers completion events from four DMA channels (receive A, receive B, transmit A, transmit B) and turns them into one interrupt request and an interrupt vector. Each channel may finish because its block count ran out (terminal count) or because it was aborted. Each cause sets its own sticky status bit. Software reads these bits to tell the two causes apart.

A channel counts as pending when its terminal-count bit is set, or when its abort bit is set and interrupts on abort are enabled. Its per-channel enable gates it, and a master enable gates the request. When status-in-vector mode is on, vector bits 3 to 1 are replaced by a 3-bit code. This code names the highest-priority enabled pending channel. With the mode off, the programmed base vector passes through unchanged. In no-vector mode the request still rises, but no vector is supplied during acknowledge. An acknowledge clears both status bits of the channel it reported. A write port also lets software clear any status bit directly.

Top module: `dmavec_irq_top`

## Requirements
- R1: After reset all status bits are 0 and `irq` is 0. With status-in-vector mode on, vector bits 3..1 read 000.
- R2: An event pulse on `tc_evt[i]` or `abort_evt[i]` sets the matching status bit at the next clock edge. The bit then holds until it is cleared.
- R3: A set abort bit makes its channel pending only while `abort_ie` is 1. A set terminal-count bit makes its channel pending regardless of `abort_ie`.
- R4: A pending channel whose `src_ie[i]` is 0 has no effect on `irq` or on the vector code.
- R5: `irq` is 1 exactly when `master_ie` is 1 and at least one enabled channel is pending.
- R6: In status-in-vector mode, `vec_out` equals `base_vec` with bits 3..1 replaced by the code. Index 0 (receive A) gives 100, index 1 (receive B) 101, index 2 (transmit A) 110 and index 3 (transmit B) 111. No enabled pending channel gives 000. Codes 001 to 011 never occur.
- R7: When several enabled channels are pending, the highest index wins: 3 beats 2, 2 beats 1, and 1 beats 0.
- R8: With status-in-vector mode off (and no-vector mode off), `vec_out` equals `base_vec`.
- R9: In no-vector mode, `irq` behaves as usual, `vec_valid` stays 0 during acknowledge, and `vec_out` is 0.
- R10: `ack` while `irq` is 1 clears both status bits of the reported channel at the clock edge and leaves the other channels alone. `ack` while `irq` is 0 changes nothing. Outside no-vector mode, `vec_valid` equals `ack && irq`.
- R11: While `clr_we` is 1, status bits selected by `clr_tc_mask` and `clr_abort_mask` clear at the clock edge. An event in the same cycle as any clear leaves its bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tc_evt | input | 4 | Terminal-count event pulses, index 0..3 = rx A, rx B, tx A, tx B |
| abort_evt | input | 4 | Abort event pulses, same indexing |
| src_ie | input | 4 | Per-channel interrupt enables |
| abort_ie | input | 1 | Lets abort status make a channel pending |
| master_ie | input | 1 | Master interrupt enable |
| status_in_vec | input | 1 | Splices source code into vector bits 3..1 |
| no_vec | input | 1 | Request without a vector |
| base_vec | input | 8 | Programmed base vector |
| ack | input | 1 | Interrupt acknowledge strobe |
| clr_we | input | 1 | Software clear strobe |
| clr_tc_mask | input | 4 | Terminal-count bits to clear |
| clr_abort_mask | input | 4 | Abort bits to clear |
| irq | output | 1 | Interrupt request |
| vec_out | output | 8 | Interrupt vector |
| vec_valid | output | 1 | Vector is being supplied for this acknowledge |
| tc_status | output | 4 | Terminal-count status bits |
| abort_status | output | 4 | Abort status bits |

## Verification
A wrong status latch shows up on `tc_status` or `abort_status` one clock after the event or clear that caused it. It also appears at once on `irq` and on vector bits 3..1, because the gating and encoding stages hold no state. A fault in the priority or enable gating shows up in the same cycle as a wrong code or request level. A full sweep over every status pattern, every enable pattern and both master enable settings exposes these faults. A wrong acknowledge clear leaves a stale bit or wipes a bystander channel. Either effect is visible on the status outputs one edge after `ack`.

// File: rtl/dmavec_pkg.sv
package dmavec_pkg;
  localparam int N_SRC    = 4;
  localparam int IDX_W    = $clog2(N_SRC);
  localparam int CODE_W   = IDX_W + 1;
  localparam int VEC_W    = 8;
  localparam int CODE_LSB = 1;

  // Source code: top bit marks "something pending", low bits give the index.
  function automatic logic [CODE_W-1:0] src_code(input logic any, input logic [IDX_W-1:0] idx);
    return any ? {1'b1, idx} : '0;
  endfunction

  // Replace the code field of a base vector.
  function automatic logic [VEC_W-1:0] splice_vec(input logic [VEC_W-1:0] base,
                                                  input logic [CODE_W-1:0] code);
    logic [VEC_W-1:0] mask;
    mask = VEC_W'({CODE_W{1'b1}}) << CODE_LSB;
    return (base & ~mask) | (VEC_W'(code) << CODE_LSB);
  endfunction
endpackage

// File: rtl/dmavec_pend.sv
module dmavec_pend #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] tc_evt,
  input  logic [N-1:0] ab_evt,
  input  logic [N-1:0] tc_clr,
  input  logic [N-1:0] ab_clr,
  output logic [N-1:0] tc_q,
  output logic [N-1:0] ab_q
);
  // A set in the same cycle as a clear wins, so no event is lost.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tc_q <= '0;
      ab_q <= '0;
    end else begin
      tc_q <= (tc_q & ~tc_clr) | tc_evt;
      ab_q <= (ab_q & ~ab_clr) | ab_evt;
    end
  end

  AST_TC_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|tc_evt) |=> ((tc_q & $past(tc_evt)) == $past(tc_evt))); // R2
  AST_AB_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|ab_evt) |=> ((ab_q & $past(ab_evt)) == $past(ab_evt))); // R11
  AST_TC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_evt == '0 && tc_clr == '0) |=> $stable(tc_q)); // R2
  AST_AB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_evt == '0 && ab_clr == '0) |=> $stable(ab_q)); // R2
endmodule

// File: rtl/dmavec_prio.sv
module dmavec_prio #(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  win_oh,
  output logic [IW-1:0] win_idx,
  output logic          any
);
  // Ascending scan: the last (highest) set index overrides earlier ones.
  always_comb begin
    win_oh  = '0;
    win_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) begin
        win_oh    = '0;
        win_oh[i] = 1'b1;
        win_idx   = IW'(i);
      end
    end
  end
  assign any = |req;
endmodule

// File: rtl/dmavec_irq_top.sv
module dmavec_irq_top
  import dmavec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] tc_evt,
  input  logic [N_SRC-1:0] abort_evt,
  input  logic [N_SRC-1:0] src_ie,
  input  logic             abort_ie,
  input  logic             master_ie,
  input  logic             status_in_vec,
  input  logic             no_vec,
  input  logic [VEC_W-1:0] base_vec,
  input  logic             ack,
  input  logic             clr_we,
  input  logic [N_SRC-1:0] clr_tc_mask,
  input  logic [N_SRC-1:0] clr_abort_mask,
  output logic             irq,
  output logic [VEC_W-1:0] vec_out,
  output logic             vec_valid,
  output logic [N_SRC-1:0] tc_status,
  output logic [N_SRC-1:0] abort_status
);
  // Named internal events for the assertions.
  logic [N_SRC-1:0]  pending;
  logic [N_SRC-1:0]  en_pend;
  logic [N_SRC-1:0]  win_oh;
  logic [IDX_W-1:0]  win_idx;
  logic              win_any;
  logic [CODE_W-1:0] code;
  logic              ack_fire;
  logic [N_SRC-1:0]  tc_clr;
  logic [N_SRC-1:0]  ab_clr;

  assign pending = tc_status | (abort_status & {N_SRC{abort_ie}});
  assign en_pend = pending & src_ie;

  dmavec_prio #(.N(N_SRC), .IW(IDX_W)) u_prio (
    .req     (en_pend),
    .win_oh  (win_oh),
    .win_idx (win_idx),
    .any     (win_any)
  );

  assign code     = src_code(win_any, win_idx);
  assign irq      = master_ie & win_any;
  assign ack_fire = ack & irq;
  assign tc_clr   = (clr_we ? clr_tc_mask    : '0) | (ack_fire ? win_oh : '0);
  assign ab_clr   = (clr_we ? clr_abort_mask : '0) | (ack_fire ? win_oh : '0);

  always_comb begin
    if (no_vec)             vec_out = '0;
    else if (status_in_vec) vec_out = splice_vec(base_vec, code);
    else                    vec_out = base_vec;
  end
  assign vec_valid = ack_fire & ~no_vec;

  dmavec_pend #(.N(N_SRC)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .tc_evt (tc_evt),
    .ab_evt (abort_evt),
    .tc_clr (tc_clr),
    .ab_clr (ab_clr),
    .tc_q   (tc_status),
    .ab_q   (abort_status)
  );

  AST_WIN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_oh)); // R7
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (code[CODE_W-1] || code == '0)); // R6
  AST_WIN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    ((win_oh & ~src_ie) == '0)); // R4
  AST_IRQ_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> code[CODE_W-1]); // R5
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && tc_evt == '0 && abort_evt == '0)
      |=> (((tc_status | abort_status) & $past(win_oh)) == '0)); // R10
  AST_NOVEC_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    no_vec |-> (!vec_valid && vec_out == '0)); // R9
endmodule

// File: tb/test_dmavec_irq_top.sv
module test_dmavec_irq_top;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [3:0] tc_evt = 0, abort_evt = 0, src_ie = 0, clr_tc_mask = 0, clr_abort_mask = 0;
  logic       abort_ie = 0, master_ie = 0, status_in_vec = 0, no_vec = 0, ack = 0, clr_we = 0;
  logic [7:0] base_vec = 0;
  logic       irq, vec_valid;
  logic [7:0] vec_out;
  logic [3:0] tc_status, abort_status;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  dmavec_irq_top i_dmavec_irq_top (
    .clk(clk), .rst_n(rst_n), .tc_evt(tc_evt), .abort_evt(abort_evt), .src_ie(src_ie),
    .abort_ie(abort_ie), .master_ie(master_ie), .status_in_vec(status_in_vec),
    .no_vec(no_vec), .base_vec(base_vec), .ack(ack), .clr_we(clr_we),
    .clr_tc_mask(clr_tc_mask), .clr_abort_mask(clr_abort_mask), .irq(irq),
    .vec_out(vec_out), .vec_valid(vec_valid), .tc_status(tc_status),
    .abort_status(abort_status)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Expected code for an enabled-pending set: 4 + highest index, or 0.
  function automatic logic [2:0] exp_code(input logic [3:0] ep);
    logic [2:0] c;
    c = 3'd0;
    for (int i = 0; i < 4; i++) if (ep[i]) c = 3'd4 + 3'(i);
    return c;
  endfunction

  function automatic logic [7:0] exp_vec(input logic [7:0] b, input logic [2:0] c);
    return {b[7:4], c, b[0]};
  endfunction

  task automatic clear_all();
    clr_we = 1; clr_tc_mask = 4'hF; clr_abort_mask = 4'hF;
    step();
    clr_we = 0; clr_tc_mask = 0; clr_abort_mask = 0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(); step();
    // R1: reset state
    status_in_vec = 1; base_vec = 8'hA5; master_ie = 1; src_ie = 4'hF;
    #1;
    check("R1 tc_status", tc_status, 0);
    check("R1 abort_status", abort_status, 0);
    check("R1 irq", irq, 0);
    check("R1 vec", vec_out, 8'hA1);
    rst_n = 1;
    step();

    // R4 R5 R6 R7 R2: exhaustive sweep of status x enable x master
    for (int p = 0; p < 16; p++)
      for (int e = 0; e < 16; e++)
        for (int m = 0; m < 2; m++) begin
          logic [3:0] ep;
          clear_all();
          tc_evt = 4'(p);
          step();
          tc_evt = 0;
          src_ie = 4'(e); master_ie = m[0];
          base_vec = 8'(p * 17 + e * 3 + m);
          status_in_vec = 1;
          #1;
          ep = 4'(p & e);
          check("R2 tc_status set", tc_status, 32'(p));
          check("R5 R4 irq", irq, 32'(m[0] & (ep != 0)));
          check("R6 R7 vec code", vec_out, exp_vec(base_vec, exp_code(ep)));
        end

    // R3: abort gating
    clear_all();
    src_ie = 4'hF; master_ie = 1; abort_ie = 0; base_vec = 8'h40;
    abort_evt = 4'b0010; step(); abort_evt = 0; #1;
    check("R2 abort_status set", abort_status, 4'b0010);
    check("R3 abort ignored irq", irq, 0);
    check("R3 abort ignored vec", vec_out, 8'h40);
    abort_ie = 1; #1;
    check("R3 abort pending irq", irq, 1);
    check("R3 abort vec rxB", vec_out, 8'h4A);

    // R8: pass-through
    status_in_vec = 0; #1;
    check("R8 base passthrough", vec_out, 8'h40);
    status_in_vec = 1;

    // R9: no-vector mode
    no_vec = 1; ack = 1; #1;
    check("R9 irq kept", irq, 1);
    check("R9 vec_valid low", vec_valid, 0);
    check("R9 vec zero", vec_out, 0);
    ack = 0; no_vec = 0;
    step();

    // R10: ack clears only reported source
    clear_all();
    tc_evt = 4'b1001; abort_evt = 4'b1100; step(); tc_evt = 0; abort_evt = 0;
    ack = 1; #1;
    check("R10 vec_valid", vec_valid, 1);
    check("R10 vec txB", vec_out, 8'h4E);
    step(); ack = 0; #1;
    check("R10 tc after ack", tc_status, 4'b0001);
    check("R10 abort after ack", abort_status, 4'b0100);
    check("R10 next winner txA", vec_out, 8'h4C);
    master_ie = 0; ack = 1; #1;
    check("R10 vec_valid no irq", vec_valid, 0);
    step(); ack = 0; #1;
    check("R10 ack without irq tc", tc_status, 4'b0001);
    check("R10 ack without irq abort", abort_status, 4'b0100);
    master_ie = 1;

    // R11: software clear, set wins
    clr_we = 1; clr_tc_mask = 4'b0001; clr_abort_mask = 4'b0100; abort_evt = 4'b0100;
    step();
    clr_we = 0; clr_tc_mask = 0; clr_abort_mask = 0; abort_evt = 0; #1;
    check("R11 tc cleared", tc_status, 0);
    check("R11 abort set wins", abort_status, 4'b0100);
    clr_we = 1; clr_abort_mask = 4'hF; step(); clr_we = 0; clr_abort_mask = 0; #1;
    check("R11 abort cleared", abort_status, 0);
    check("R11 irq dropped", irq, 0);
    // R10 R11: event during ack keeps bit
    tc_evt = 4'b0100; step(); ack = 1; tc_evt = 4'b0100; step(); ack = 0; tc_evt = 0; #1;
    check("R11 event beats ack clear", tc_status, 4'b0100);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule